// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block is the controller end of a byte-wide command channel. A host bus reaches it through four byte registers. Embedded logic on the other side consumes host bytes and produces response bytes. The host pushes each byte in two writes: first the byte into the data register, then the "byte pending" bit in the control register. The block drops that bit once the command decoder has taken the byte. Responses travel back the other way. The decoder loads a byte and raises a "response ready" status bit. The host reads the byte and then writes a one to that status bit to release it.

Above the handshake sits a small command decoder. It recognises four multi-byte transactions:
- version query
- configuration byte read
- configuration byte write
- abort by slot index

The real command engine is not part of this block. A stub responder stands in for it, holding a small configuration store, a fixed version word and a slot-range abort rule.

Register map (host_addr):
- 0: data. A write loads the outgoing byte. A read returns the response byte.
- 1: control. Bit 0 is byte pending.
- 2: status. Bit 0 is response ready, bit 1 is overrun, both write-one-to-clear.
- 3: echo. A read returns the outgoing byte last accepted into the data register.

Top module: `mbox_host_mailbox`

## Requirements
- R1: After synchronous reset, control reads 0x00, status reads 0x00 and the data register reads 0x00.
- R2: Writing control with bit 0 set raises byte pending (control bit 0). The bit reads 0 again once the decoder has consumed the byte, within a few cycles while no response is outstanding.
- R3: A write to the data register while byte pending is set is ignored: echo keeps the earlier byte. Such a write also sets the overrun bit (status bit 1). Overrun stays set until the host writes status with bit 1 set.
- R4: Response ready (status bit 0) is cleared only by a status write with bit 0 set. A status write with bit 0 clear leaves it set.
- R5: Command 0x01 (version) returns two response bytes, low byte first, from the version word. The default version word is 0x0A17.
- R6: Command 0x03 followed by an address byte and a value byte writes the configuration store and produces no response byte. The store has 16 entries addressed by the low 4 bits of the address byte, and all entries read 0x00 after reset.
- R7: Command 0x02 followed by an address byte returns one response byte holding the addressed configuration entry.
- R8: Command 0x04 followed by a slot byte returns one status byte. The byte is 0x00 when the slot is below the slot count (default 32) and 0x01 otherwise.
- R9: Any other command code is dropped without a response, and the decoder waits for a new command byte.
- R10: Response ready is never raised again until the previous response has been acknowledged. A later response byte stays hidden until then.
- R11: While a response is being returned, the decoder does not consume host bytes, so byte pending stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |

## Verification
The bench goes after each place where a handshake can slip.

A design that lets a busy-time data write through would corrupt the pending byte, and the echo register shows this. A design with the overrun bit not sticky would lose the error before the host looks.

A design that re-raises response ready before the acknowledge would overwrite the low version byte. A decoder that sends the version bytes in the wrong order would swap them.

A sweep of all 252 unknown command codes would hang a decoder that does not fall back to idle, or produce a spurious response. Address aliasing in the configuration sweep catches a decoder that uses more address bits than the store has. The abort sweep across the slot limit catches an off-by-one in the range test.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int BYTE_W = 8;

    // host register select
    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_ECHO = 2'd3;

    // bit positions
    localparam int CTRL_PEND_BIT = 0;
    localparam int STAT_RDY_BIT  = 0;
    localparam int STAT_OVR_BIT  = 1;

    // command codes
    localparam logic [7:0] CMD_VERSION = 8'h01;
    localparam logic [7:0] CMD_CFG_RD  = 8'h02;
    localparam logic [7:0] CMD_CFG_WR  = 8'h03;
    localparam logic [7:0] CMD_ABORT   = 8'h04;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OPERAND = 2'd1,
        ST_VALUE   = 2'd2,
        ST_RESP    = 2'd3
    } dec_state_e;

    function automatic logic takes_operand(input logic [7:0] code);
        return (code == CMD_CFG_RD) || (code == CMD_CFG_WR) || (code == CMD_ABORT);
    endfunction

    function automatic logic is_known(input logic [7:0] code);
        return (code == CMD_VERSION) || takes_operand(code);
    endfunction

endpackage

// File: rtl/mbox_host_regs.sv
module mbox_host_regs
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              out_flag,
    output logic [BYTE_W-1:0] out_byte,
    input  logic              out_accept,
    input  logic              in_set,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_flag
);

    logic              pend_q;
    logic [BYTE_W-1:0] obyte_q;
    logic              rdy_q;
    logic [BYTE_W-1:0] ibyte_q;
    logic              ovr_q;

    logic wr_data, wr_ctrl, wr_stat;
    assign wr_data = wr_en && (addr == REG_DATA);
    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_stat = wr_en && (addr == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            obyte_q <= '0;
            rdy_q   <= 1'b0;
            ibyte_q <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (wr_data && !pend_q)
                obyte_q <= wdata;

            if (out_accept)
                pend_q <= 1'b0;
            else if (wr_ctrl && wdata[CTRL_PEND_BIT])
                pend_q <= 1'b1;

            if (wr_data && pend_q)
                ovr_q <= 1'b1;
            else if (wr_stat && wdata[STAT_OVR_BIT])
                ovr_q <= 1'b0;

            if (in_set) begin
                rdy_q   <= 1'b1;
                ibyte_q <= in_byte;
            end else if (wr_stat && wdata[STAT_RDY_BIT]) begin
                rdy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_DATA: rdata = ibyte_q;
            REG_CTRL: rdata[CTRL_PEND_BIT] = pend_q;
            REG_STAT: begin
                rdata[STAT_RDY_BIT] = rdy_q;
                rdata[STAT_OVR_BIT] = ovr_q;
            end
            default:  rdata = obyte_q;
        endcase
    end

    assign out_flag = pend_q;
    assign out_byte = obyte_q;
    assign in_flag  = rdy_q;

    // R10: a new response is loaded only into an empty slot
    a_r10_no_reraise: assert property (@(posedge clk) disable iff (rst)
        in_set |-> !rdy_q);

    // R2: consumption only of a pending byte
    a_r2_accept_pending: assert property (@(posedge clk) disable iff (rst)
        out_accept |-> pend_q);

    // R3: overrun is sticky until cleared
    a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !(wr_stat && wdata[STAT_OVR_BIT])) |=> ovr_q);

    // R3: a busy-time data write leaves the pending byte untouched
    a_r3_byte_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_data && pend_q) |=> $stable(obyte_q));

    // R4: response ready holds until a one is written to it
    a_r4_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (rdy_q && !(wr_stat && wdata[STAT_RDY_BIT])) |=> rdy_q);

endmodule

// File: rtl/mbox_stub_responder.sv
module mbox_stub_responder
    import mbox_pkg::*;
#(
    parameter int          CFG_AW     = 4,
    parameter int          NUM_SLOTS  = 32,
    parameter logic [15:0] FW_VERSION = 16'h0A17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr_en,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    input  logic [BYTE_W-1:0] abort_slot,
    output logic [BYTE_W-1:0] abort_status,
    output logic [15:0]       version
);

    localparam int CFG_DEPTH = 1 << CFG_AW;

    logic [BYTE_W-1:0] store_q [CFG_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_DEPTH; i++)
                store_q[i] <= '0;
        end else if (cfg_wr_en) begin
            store_q[cfg_addr] <= cfg_wdata;
        end
    end

    assign cfg_rdata    = store_q[cfg_addr];
    assign abort_status = (int'(abort_slot) < NUM_SLOTS) ? 8'h00 : 8'h01;
    assign version      = FW_VERSION;

endmodule

// File: rtl/mbox_cmd_decoder.sv
module mbox_cmd_decoder
    import mbox_pkg::*;
#(
    parameter int CFG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_flag,
    input  logic [BYTE_W-1:0] out_byte,
    output logic              out_accept,
    input  logic              in_flag,
    output logic              in_set,
    output logic [BYTE_W-1:0] in_byte,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic              cfg_wr_en,
    output logic [BYTE_W-1:0] cfg_wdata,
    input  logic [BYTE_W-1:0] cfg_rdata,
    output logic [BYTE_W-1:0] abort_slot,
    input  logic [BYTE_W-1:0] abort_status,
    input  logic [15:0]       version
);

    dec_state_e        state_q, state_d;
    logic [BYTE_W-1:0] cmd_q, cmd_d;
    logic [BYTE_W-1:0] addr_q, addr_d;
    logic [BYTE_W-1:0] lo_q, lo_d;
    logic [BYTE_W-1:0] hi_q, hi_d;
    logic [1:0]        left_q, left_d;

    always_comb begin
        state_d    = state_q;
        cmd_d      = cmd_q;
        addr_d     = addr_q;
        lo_d       = lo_q;
        hi_d       = hi_q;
        left_d     = left_q;
        in_set     = 1'b0;
        cfg_wr_en  = 1'b0;
        out_accept = out_flag && (state_q != ST_RESP);
        unique case (state_q)
            ST_IDLE: begin
                if (out_accept) begin
                    if (out_byte == CMD_VERSION) begin
                        lo_d    = version[7:0];
                        hi_d    = version[15:8];
                        left_d  = 2'd2;
                        state_d = ST_RESP;
                    end else if (takes_operand(out_byte)) begin
                        cmd_d   = out_byte;
                        state_d = ST_OPERAND;
                    end
                end
            end
            ST_OPERAND: begin
                if (out_accept) begin
                    addr_d = out_byte;
                    if (cmd_q == CMD_CFG_WR) begin
                        state_d = ST_VALUE;
                    end else begin
                        lo_d    = (cmd_q == CMD_CFG_RD) ? cfg_rdata : abort_status;
                        left_d  = 2'd1;
                        state_d = ST_RESP;
                    end
                end
            end
            ST_VALUE: begin
                if (out_accept) begin
                    cfg_wr_en = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_RESP: begin
                if (!in_flag && left_q != 2'd0) begin
                    in_set = 1'b1;
                    lo_d   = hi_q;
                    left_d = left_q - 2'd1;
                    if (left_q == 2'd1)
                        state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            addr_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            lo_q    <= lo_d;
            hi_q    <= hi_d;
            left_q  <= left_d;
        end
    end

    assign in_byte    = lo_q;
    assign cfg_addr   = (state_q == ST_VALUE) ? addr_q[CFG_AW-1:0] : out_byte[CFG_AW-1:0];
    assign cfg_wdata  = out_byte;
    assign abort_slot = out_byte;

    // R11: no host byte is consumed while a response is in flight
    a_r11_hold_in_resp: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESP) |-> !out_accept);

    // R9: an unknown command code leaves the decoder idle
    a_r9_drop_unknown: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && out_accept && !is_known(out_byte)) |=> (state_q == ST_IDLE));

    // R6: a configuration write never produces a response byte
    a_r6_write_silent: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VALUE) |-> !in_set);

endmodule

// File: rtl/mbox_host_mailbox.sv
module mbox_host_mailbox
    import mbox_pkg::*;
#(
    parameter int          CFG_AW     = 4,
    parameter int          NUM_SLOTS  = 32,
    parameter logic [15:0] FW_VERSION = 16'h0A17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);

    logic              out_flag, out_accept, in_flag, in_set;
    logic [BYTE_W-1:0] out_byte, in_byte;
    logic [CFG_AW-1:0] cfg_addr;
    logic              cfg_wr_en;
    logic [BYTE_W-1:0] cfg_wdata, cfg_rdata, abort_slot, abort_status;
    logic [15:0]       version;

    mbox_host_regs regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (host_wr),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .rdata      (host_rdata),
        .out_flag   (out_flag),
        .out_byte   (out_byte),
        .out_accept (out_accept),
        .in_set     (in_set),
        .in_byte    (in_byte),
        .in_flag    (in_flag)
    );

    mbox_cmd_decoder #(.CFG_AW(CFG_AW)) dec_i (
        .clk          (clk),
        .rst          (rst),
        .out_flag     (out_flag),
        .out_byte     (out_byte),
        .out_accept   (out_accept),
        .in_flag      (in_flag),
        .in_set       (in_set),
        .in_byte      (in_byte),
        .cfg_addr     (cfg_addr),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .abort_slot   (abort_slot),
        .abort_status (abort_status),
        .version      (version)
    );

    mbox_stub_responder #(
        .CFG_AW     (CFG_AW),
        .NUM_SLOTS  (NUM_SLOTS),
        .FW_VERSION (FW_VERSION)
    ) resp_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_addr     (cfg_addr),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .abort_slot   (abort_slot),
        .abort_status (abort_status),
        .version      (version)
    );

endmodule

// File: tb/mbox_host_mailbox_tb.sv
module mbox_host_mailbox_tb_top;

    localparam logic [1:0]  A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_ECHO = 2'd3;
    localparam logic [15:0] EXP_VER = 16'h0A17;
    localparam int          SLOTS   = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mbox_host_mailbox dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    // returns 1 when byte pending cleared within the poll window
    task automatic send_byte(input logic [7:0] b, output bit ok);
        logic [7:0] v;
        hwr(A_DATA, b);
        hwr(A_CTRL, 8'h01);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            hrd(A_CTRL, v);
            if (!v[0]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic recv_byte(output logic [7:0] b, output bit ok);
        logic [7:0] v;
        ok = 1'b0;
        b  = 8'h00;
        for (int i = 0; i < 40; i++) begin
            hrd(A_STAT, v);
            if (v[0]) begin ok = 1'b1; break; end
        end
        if (ok) begin
            hrd(A_DATA, b);
            hwr(A_STAT, 8'h01);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v, b;
        bit ok, ok2;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hrd(A_CTRL, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        hrd(A_STAT, v); chk(v == 8'h00, "R1 stat", v, 0);
        hrd(A_DATA, v); chk(v == 8'h00, "R1 data", v, 0);

        // R2 byte pending rises then clears
        hwr(A_DATA, 8'hEE);
        hwr(A_CTRL, 8'h01);
        // pending was set at that edge; decoder took it the same edge onward
        send_byte(8'hEF, ok);
        chk(ok, "R2 pending clears", ok, 1);
        hrd(A_STAT, v); chk(v == 8'h00, "R2 no response for junk", v, 0);

        // R5/R10 version, low first, second held until ack
        send_byte(8'h01, ok);
        chk(ok, "R5 version cmd consumed", ok, 1);
        hrd(A_STAT, v); chk(v[0] == 1'b1, "R5 ready raised", v, 1);
        hrd(A_DATA, v); chk(v == EXP_VER[7:0], "R5 low byte", v, EXP_VER[7:0]);
        repeat (6) @(negedge clk);
        hrd(A_STAT, v); chk(v[0] == 1'b1, "R10 ready held", v, 1);
        hrd(A_DATA, v); chk(v == EXP_VER[7:0], "R10 low byte not overwritten", v, EXP_VER[7:0]);
        // R4 status write with bit 0 clear has no effect
        hwr(A_STAT, 8'h00);
        hwr(A_STAT, 8'h02);
        hrd(A_STAT, v); chk(v[0] == 1'b1, "R4 zero write ignored", v, 1);
        hwr(A_STAT, 8'h01);
        recv_byte(b, ok);
        chk(ok && b == EXP_VER[15:8], "R5 high byte", b, EXP_VER[15:8]);
        hrd(A_STAT, v); chk(v[0] == 1'b0, "R4 cleared by ack", v, 0);

        // R3/R11 overrun while decoder is busy answering
        send_byte(8'h01, ok);
        hwr(A_DATA, 8'h5A);
        hwr(A_CTRL, 8'h01);
        repeat (4) @(negedge clk);
        hrd(A_CTRL, v); chk(v[0] == 1'b1, "R11 pending held during response", v, 1);
        hwr(A_DATA, 8'hC3);
        hrd(A_ECHO, v); chk(v == 8'h5A, "R3 busy write ignored", v, 8'h5A);
        hrd(A_STAT, v); chk(v[1] == 1'b1, "R3 overrun set", v, 2);
        repeat (3) @(negedge clk);
        hrd(A_STAT, v); chk(v[1] == 1'b1, "R3 overrun sticky", v, 2);
        hwr(A_STAT, 8'h02);
        hrd(A_STAT, v); chk(v[1] == 1'b0, "R3 overrun cleared", v, 0);
        recv_byte(b, ok);
        recv_byte(b, ok2);
        chk(ok && ok2 && b == EXP_VER[15:8], "R11 response drained", b, EXP_VER[15:8]);
        // 0x5A now consumed as an unknown command
        for (int i = 0; i < 20; i++) hrd(A_CTRL, v);
        chk(v[0] == 1'b0, "R9 held byte consumed after response", v, 0);
        hrd(A_STAT, v); chk(v == 8'h00, "R9 held unknown no response", v, 0);

        // R7 reset content of store
        send_byte(8'h02, ok); send_byte(8'h05, ok);
        recv_byte(b, ok);
        chk(ok && b == 8'h00, "R7 reset store reads zero", b, 0);

        // R6/R7 configuration sweep with aliasing
        for (int a = 0; a < 16; a++) begin
            send_byte(8'h03, ok); send_byte(8'(a), ok); send_byte(8'((a * 37 + 11) & 255), ok2);
            hrd(A_STAT, v);
            chk(ok && ok2 && v[0] == 1'b0, "R6 write silent", v, 0);
        end
        for (int a = 0; a < 16; a++) begin
            send_byte(8'h02, ok); send_byte(8'(a + 16), ok);
            recv_byte(b, ok);
            chk(ok && b == 8'((a * 37 + 11) & 255), "R7 read back", b, (a * 37 + 11) & 255);
        end

        // R8 abort sweep across the slot limit
        for (int s = 0; s < 64; s++) begin
            send_byte(8'h04, ok); send_byte(8'(s), ok);
            recv_byte(b, ok);
            chk(ok && b == ((s < SLOTS) ? 8'h00 : 8'h01), "R8 abort status", b, (s < SLOTS) ? 0 : 1);
        end
        send_byte(8'h04, ok); send_byte(8'hFF, ok);
        recv_byte(b, ok);
        chk(ok && b == 8'h01, "R8 abort top slot", b, 1);

        // R9 every unknown code dropped
        for (int c = 0; c < 256; c++) begin
            if (c >= 1 && c <= 4) continue;
            send_byte(8'(c), ok);
            hrd(A_STAT, v);
            chk(ok && v[0] == 1'b0, "R9 unknown dropped", v, 0);
        end
        send_byte(8'h01, ok);
        recv_byte(b, ok);
        chk(ok && b == EXP_VER[7:0], "R9 idle after unknowns", b, EXP_VER[7:0]);
        recv_byte(b, ok);
        chk(ok && b == EXP_VER[15:8], "R9 idle after unknowns hi", b, EXP_VER[15:8]);

        summary();
        $finish;
    end

endmodule